// File: doc/BRIEF.md
# Receive Ring Descriptor Writeback

This unit sits between a receive byte stream and a descriptor ring held in system memory. A frame is announced by a one-cycle start strobe that carries its byte count, and its payload bytes follow under a valid/ready handshake. For each announced frame the unit decides whether it can take it. If it can, it claims the descriptor at the hardware pointer and reads the buffer address from word 0 of that descriptor. It then writes the payload plus four zero bytes into that buffer and writes a status into the descriptor. Finally it advances the hardware pointer around the ring.

Software owns the software pointer. The ring is empty for the hardware when the two pointers are equal. The unit reports this as a level on `can_accept`, and it signals the result of each frame with single-cycle event pulses. A frame that is refused or that finds no descriptor is still drained from the byte stream, so the source never stalls. Buffer addresses are taken to be word aligned.

A descriptor is four 32-bit words. Word 0 holds the buffer address, word 1 is an acceleration status and word 2 is the length status. Word 3 is a DMA status.

Top module: `rxwb_top`

## Requirements
- R1: A frame that starts while `soft_rst` is high, `link_up` is low, `rx_en` is low or `rx_dma_en` is low is drained. It causes no memory read, no memory write and no event pulse, and it leaves the hardware pointer unchanged.
- R2: A frame that starts while all enables are good and the hardware pointer equals the software pointer raises `ev_desc_empty` for one cycle. It is drained with no memory write, and the hardware pointer is unchanged.
- R3: `can_accept` is high exactly when the hardware pointer differs from the software pointer.
- R4: A frame of fewer than 1519 bytes is written byte-for-byte, little-endian within each word, starting at the buffer address from descriptor word 0. Four zero bytes follow the payload. Byte lanes past the last padded byte are not written.
- R5: For a good frame, descriptor word 2 is `{16'h0, v}`. Here v = (L + 4 + 3) mod 65536, where L is the frame length. The low two bits of v are the end byte and bits 15:2 are the word count.
- R6: When bit 1 of v is set, 4 is added to v (mod 65536) before it is written.
- R7: A good frame raises `ev_dma_done` and `ev_valid` together for one cycle, after its descriptor write, and does not raise `ev_frame_err`.
- R8: A frame of 1519 bytes or more writes nothing to its buffer. It writes descriptor word 2 as 32'h0010_0000 (only bit 20 set), and it raises `ev_frame_err` alone.
- R9: Descriptor writeback writes word 1 and word 3 as zero and rewrites word 0 with the buffer address that was read from it.
- R10: After each descriptor writeback the hardware pointer moves up by 16. It returns to the base when the result reaches base plus size. A write to the base register (select 0) also loads the hardware pointer.
- R11: All buffer writes of a frame come before any of its descriptor writes.
- R12: A write to the size register (select 1) sets the ring size to (data AND 0xFFF0) + 16. Select 2 loads the hardware pointer and select 3 loads the software pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Ring register write strobe |
| cfg_sel | input | 2 | 0 base, 1 size, 2 hardware pointer, 3 software pointer |
| cfg_wdata | input | 32 | Ring register write data |
| soft_rst | input | 1 | Unit held in reset; frames refused |
| link_up | input | 1 | Link state |
| rx_en | input | 1 | Receive enable |
| rx_dma_en | input | 1 | Receive DMA enable |
| rx_start | input | 1 | Frame start strobe, taken when idle |
| rx_len | input | 16 | Frame byte count, sampled with `rx_start` |
| rx_valid | input | 1 | Payload byte valid |
| rx_byte | input | 8 | Payload byte |
| rx_ready | output | 1 | Unit takes the byte this cycle |
| mem_re | output | 1 | Descriptor read strobe |
| mem_raddr | output | 32 | Descriptor read address |
| mem_rdata | input | 32 | Read data, one cycle after `mem_re` |
| mem_we | output | 1 | Memory write strobe |
| mem_waddr | output | 32 | Word write address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte-lane enables |
| ev_dma_done | output | 1 | Good frame stored pulse |
| ev_valid | output | 1 | Good frame valid pulse |
| ev_frame_err | output | 1 | Oversize frame pulse |
| ev_desc_empty | output | 1 | No descriptor available pulse |
| can_accept | output | 1 | Hardware and software pointers differ |
| hw_ptr | output | 32 | Current hardware pointer |

## Verification
The hardest case to reach is a ring wrap that lands on a frame with a particular length code. The pointer has to reach base plus size on the same descriptor whose length sets bit 1 of the encoded value. Without that, the wrap and the +4 adjustment are never seen together in one frame. The stimulus gets there in three steps. It programs a four-entry ring, runs directed lengths 0 to 3 so that every end-byte value shows up, and then feeds a long stream of random lengths that keeps walking the ring. The empty-ring case needs the software pointer to be moved onto the hardware pointer between frames, and the bench does this directly.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;
  localparam int LEN_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DREAD, ST_DWAIT, ST_DATA, ST_DRAIN, ST_DESC
  } rx_state_e;

  localparam logic [31:0] STAT_TOO_LONG = 32'h0010_0000;

  // length code: rounded end-byte/word count with the +4 fix-up on bit 1
  function automatic logic [15:0] len_code(input logic [15:0] total);
    logic [15:0] v;
    v = total + 16'd3;
    if (v[1]) v = v + 16'd4;
    return v;
  endfunction

  // byte enables for lanes 0..lane
  function automatic logic [3:0] lanes_upto(input logic [1:0] lane);
    logic [4:0] m;
    m = (5'b00010 << lane) - 5'd1;
    return m[3:0];
  endfunction
endpackage

// File: rtl/rxwb_ring.sv
module rxwb_ring #(
  parameter int AW     = 32,
  parameter int STRIDE = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic          advance,
  output logic [AW-1:0] base,
  output logic [AW-1:0] hw,
  output logic          nonempty
);
  localparam logic [AW-1:0] STEP   = AW'(STRIDE);
  localparam logic [AW-1:0] MINSZ  = AW'(16);

  logic [AW-1:0] size_q, sw_q, step_ptr, next_ptr;

  assign step_ptr = hw + STEP;
  assign next_ptr = (step_ptr >= base + size_q) ? base : step_ptr;
  assign nonempty = (hw != sw_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base   <= '0;
      size_q <= MINSZ;
      hw     <= '0;
      sw_q   <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: begin base <= AW'(cfg_wdata); hw <= AW'(cfg_wdata); end
        2'd1: size_q <= AW'({cfg_wdata[15:4], 4'b0000}) + MINSZ;
        2'd2: hw <= AW'(cfg_wdata);
        default: sw_q <= AW'(cfg_wdata);
      endcase
    end else if (advance) begin
      hw <= next_ptr;
    end
  end
endmodule

// File: rtl/rxwb_pack.sv
module rxwb_pack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step,
  input  logic [1:0]  lane,
  input  logic [7:0]  byte_in,
  output logic [31:0] word_out,
  output logic [3:0]  be_out
);
  logic [31:0] acc;

  always_comb begin
    word_out = acc;
    word_out[lane*8 +: 8] = byte_in;
    be_out = rxwb_pkg::lanes_upto(lane);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else if (step) acc[lane*8 +: 8] <= byte_in;
  end
endmodule

// File: rtl/rxwb_top.sv
module rxwb_top #(
  parameter int AW       = 32,
  parameter int MAX_GOOD = 1519,
  parameter int STRIDE   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic          soft_rst,
  input  logic          link_up,
  input  logic          rx_en,
  input  logic          rx_dma_en,
  input  logic          rx_start,
  input  logic [15:0]   rx_len,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  output logic          rx_ready,
  output logic          mem_re,
  output logic [AW-1:0] mem_raddr,
  input  logic [31:0]   mem_rdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_be,
  output logic          ev_dma_done,
  output logic          ev_valid,
  output logic          ev_frame_err,
  output logic          ev_desc_empty,
  output logic          can_accept,
  output logic [AW-1:0] hw_ptr
);
  import rxwb_pkg::*;

  localparam logic [15:0] LIMIT = 16'(MAX_GOOD);

  rx_state_e     state;
  logic [15:0]   len_q, idx;
  logic [AW-1:0] buf_addr, ring_base;
  logic [1:0]    beat;
  logic          oversize, wb_pend;

  // named internal events (also observed by the checker)
  logic        start_take, refuse, in_payload, data_step, last_byte;
  logic        buf_wr, desc_wr, desc_last;
  logic [15:0] total;
  logic [7:0]  byte_in;
  logic [31:0] pack_word, desc_word;
  logic [3:0]  pack_be;

  assign total      = len_q + 16'd4;
  assign refuse     = soft_rst | ~link_up | ~rx_en | ~rx_dma_en;
  assign start_take = (state == ST_IDLE) && rx_start;
  assign in_payload = idx < len_q;
  assign byte_in    = in_payload ? rx_byte : 8'h00;
  assign data_step  = (state == ST_DATA) && (in_payload ? rx_valid : 1'b1);
  assign last_byte  = idx == total - 16'd1;
  assign buf_wr     = data_step && ((idx[1:0] == 2'd3) || last_byte);
  assign desc_wr    = (state == ST_DESC);
  assign desc_last  = desc_wr && (beat == 2'd3);

  assign rx_ready = ((state == ST_DATA) && in_payload) ||
                    ((state == ST_DRAIN) && (idx != len_q));

  rxwb_ring #(.AW(AW), .STRIDE(STRIDE)) u_ring (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .advance(desc_last), .base(ring_base),
    .hw(hw_ptr), .nonempty(can_accept)
  );

  rxwb_pack u_pack (
    .clk(clk), .rst_n(rst_n), .step(data_step), .lane(idx[1:0]),
    .byte_in(byte_in), .word_out(pack_word), .be_out(pack_be)
  );

  always_comb begin
    case (beat)
      2'd0:    desc_word = 32'(buf_addr);
      2'd2:    desc_word = oversize ? STAT_TOO_LONG : {16'h0, len_code(total)};
      default: desc_word = 32'h0;
    endcase
  end

  assign mem_re    = (state == ST_DREAD);
  assign mem_raddr = hw_ptr;
  assign mem_we    = buf_wr || desc_wr;
  assign mem_waddr = desc_wr ? hw_ptr + AW'({beat, 2'b00})
                             : buf_addr + AW'({idx[15:2], 2'b00});
  assign mem_wdata = desc_wr ? desc_word : pack_word;
  assign mem_be    = desc_wr ? 4'hF : pack_be;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      len_q         <= '0;
      idx           <= '0;
      buf_addr      <= '0;
      beat          <= '0;
      oversize      <= 1'b0;
      wb_pend       <= 1'b0;
      ev_dma_done   <= 1'b0;
      ev_valid      <= 1'b0;
      ev_frame_err  <= 1'b0;
      ev_desc_empty <= 1'b0;
    end else begin
      ev_dma_done   <= 1'b0;
      ev_valid      <= 1'b0;
      ev_frame_err  <= 1'b0;
      ev_desc_empty <= 1'b0;
      case (state)
        ST_IDLE: if (rx_start) begin
          len_q    <= rx_len;
          idx      <= '0;
          oversize <= rx_len >= LIMIT;
          wb_pend  <= 1'b0;
          if (refuse) begin
            state <= ST_DRAIN;
          end else if (!can_accept) begin
            state         <= ST_DRAIN;
            ev_desc_empty <= 1'b1;
          end else begin
            state   <= ST_DREAD;
            wb_pend <= 1'b1;
          end
        end
        ST_DREAD: state <= ST_DWAIT;
        ST_DWAIT: begin
          buf_addr <= AW'(mem_rdata);
          beat     <= '0;
          state    <= oversize ? ST_DRAIN : ST_DATA;
        end
        ST_DATA: if (data_step) begin
          idx <= idx + 16'd1;
          if (last_byte) state <= ST_DESC;
        end
        ST_DRAIN: begin
          if (idx == len_q) state <= wb_pend ? ST_DESC : ST_IDLE;
          else if (rx_valid) idx <= idx + 16'd1;
        end
        ST_DESC: begin
          beat <= beat + 2'd1;
          if (beat == 2'd3) begin
            state        <= ST_IDLE;
            ev_dma_done  <= ~oversize;
            ev_valid     <= ~oversize;
            ev_frame_err <= oversize;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxwb_chk.sv
module rxwb_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_take,
  input logic          refuse,
  input logic          can_accept,
  input logic          mem_re,
  input logic          ev_desc_empty,
  input logic          ev_dma_done,
  input logic          ev_valid,
  input logic          ev_frame_err,
  input logic          buf_wr,
  input logic          desc_wr,
  input logic          desc_last,
  input logic          cfg_we,
  input logic [AW-1:0] hw_ptr,
  input logic [AW-1:0] ring_base
);
  assert_refused_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_take && refuse |=> !mem_re && !ev_desc_empty);

  assert_empty_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_take && !refuse && !can_accept |=> ev_desc_empty && !mem_re);

  assert_good_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> ev_dma_done && !ev_frame_err);

  assert_err_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame_err |-> !ev_valid && !ev_dma_done);

  assert_ptr_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    desc_last && !cfg_we |=>
      (hw_ptr == $past(hw_ptr) + AW'(16)) || (hw_ptr == ring_base));

  assert_desc_after_buf_R11: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr |=> !buf_wr);
endmodule

bind rxwb_top rxwb_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_take(start_take), .refuse(refuse),
  .can_accept(can_accept), .mem_re(mem_re), .ev_desc_empty(ev_desc_empty),
  .ev_dma_done(ev_dma_done), .ev_valid(ev_valid), .ev_frame_err(ev_frame_err),
  .buf_wr(buf_wr), .desc_wr(desc_wr), .desc_last(desc_last), .cfg_we(cfg_we),
  .hw_ptr(hw_ptr), .ring_base(ring_base)
);

// File: tb/tb_rxwb_top.sv
`timescale 1ns/1ps
module tb_rxwb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0; logic [1:0] cfg_sel = 0; logic [31:0] cfg_wdata = 0;
  logic soft_rst = 0, link_up = 1, rx_en = 1, rx_dma_en = 1;
  logic rx_start = 0; logic [15:0] rx_len = 0;
  logic rx_valid = 0; logic [7:0] rx_byte = 0;
  logic rx_ready, mem_re, mem_we, can_accept;
  logic [31:0] mem_raddr, mem_waddr, mem_wdata, hw_ptr;
  logic [31:0] mem_rdata = 0;
  logic [3:0] mem_be;
  logic ev_dma_done, ev_valid, ev_frame_err, ev_desc_empty;

  always #2 clk = ~clk;

  rxwb_top dut (.*);

  int nchk = 0, nerr = 0;
  logic [31:0] mem [int unsigned];
  int wr_cnt, rd_cnt, n_done, n_valid, n_err, n_empty, late_buf;
  bit desc_seen;
  logic [31:0] b_base, b_size, b_hw;
  int fno = 0;

  localparam logic [31:0] RING = 32'h1000;

  function automatic logic [31:0] rd(int unsigned a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  function automatic logic [7:0] rd_byte(logic [31:0] a);
    logic [31:0] w;
    w = rd(a & 32'hFFFF_FFFC);
    return w[8*a[1:0] +: 8];
  endfunction

  function automatic logic [7:0] pat(int seed, int i);
    return 8'(seed * 7 + i * 13 + (i >> 3));
  endfunction

  // length status computed by words and end byte
  function automatic logic [31:0] exp_code(int len, output bit adj);
    int t, words, endb, v;
    t = len + 4;
    words = (t + 3) / 4;
    endb  = (t + 3) % 4;
    v = words * 4 + endb;
    adj = (endb >= 2);
    if (adj) v = v + 4;
    return 32'(v % 65536);
  endfunction

  function automatic logic [31:0] model_next(logic [31:0] p);
    logic [31:0] n;
    n = p + 32'd16;
    if (n >= b_base + b_size) n = b_base;
    return n;
  endfunction

  always @(posedge clk) begin
    if (mem_re) begin mem_rdata <= rd(mem_raddr); rd_cnt++; end
    if (mem_we) begin
      logic [31:0] w;
      w = rd(mem_waddr);
      for (int k = 0; k < 4; k++) if (mem_be[k]) w[8*k +: 8] = mem_wdata[8*k +: 8];
      mem[mem_waddr] = w;
      wr_cnt++;
      if (mem_waddr < 32'h1_0000) desc_seen = 1;
      else if (desc_seen) late_buf++;
    end
    if (ev_dma_done) n_done++;
    if (ev_valid) n_valid++;
    if (ev_frame_err) n_err++;
    if (ev_desc_empty) n_empty++;
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cfg(logic [1:0] sel, logic [31:0] val);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 0;
    case (sel)
      2'd0: begin b_base = val; b_hw = val; end
      2'd1: b_size = {16'h0, val[15:4], 4'h0} + 32'd16;
      2'd2: b_hw = val;
      default: ;
    endcase
  endtask

  task automatic clr_counts();
    wr_cnt = 0; rd_cnt = 0; n_done = 0; n_valid = 0; n_err = 0; n_empty = 0;
    late_buf = 0; desc_seen = 0;
  endtask

  task automatic send(int len, int seed, bit gaps);
    rx_start = 1; rx_len = 16'(len);
    @(negedge clk);
    rx_start = 0;
    for (int i = 0; i < len; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin rx_valid = 0; @(negedge clk); end
      rx_valid = 1; rx_byte = pat(seed, i);
      while (!rx_ready) @(negedge clk);
      @(negedge clk);
    end
    rx_valid = 0;
    repeat (14) @(negedge clk);
  endtask

  task automatic prep(output logic [31:0] ba, input int len);
    fno++;
    ba = 32'h1_0000 + 32'(fno) * 32'h1000;
    mem[b_hw] = ba;
    for (int k = 1; k < 4; k++) mem[b_hw + 32'(4*k)] = 32'hDEAD_BEEF;
    for (int k = 0; k < (len + 12) / 4 && k < 8; k++) mem[ba + 32'(4*k)] = 32'hA5A5_A5A5;
    for (int k = 8; k < (len + 12) / 4; k++) mem[ba + 32'(4*k)] = 32'hA5A5_A5A5;
    clr_counts();
  endtask

  task automatic good_frame(int len, int seed, bit gaps);
    logic [31:0] ba, d, code, nx;
    int bad;
    bit adj;
    d = b_hw;
    prep(ba, len);
    send(len, seed, gaps);
    chk("R7", "dma done pulses", 32'(n_done), 1);
    chk("R7", "valid pulses", 32'(n_valid), 1);
    chk("R7", "frame error pulses", 32'(n_err), 0);
    bad = 0;
    for (int i = 0; i < len; i++) if (rd_byte(ba + 32'(i)) !== pat(seed, i)) bad++;
    chk("R4", "payload byte mismatches", 32'(bad), 0);
    bad = 0;
    for (int i = len; i < len + 4; i++) if (rd_byte(ba + 32'(i)) !== 8'h00) bad++;
    chk("R4", "nonzero pad bytes", 32'(bad), 0);
    if ((len % 4) != 0)
      chk("R4", "lane past pad untouched", {24'h0, rd_byte(ba + 32'(len + 4))}, 32'hA5);
    code = exp_code(len, adj);
    chk(adj ? "R6" : "R5", "length status word", rd(d + 8), code);
    chk("R9", "word0 buffer address", rd(d), ba);
    chk("R9", "word1 zero", rd(d + 4), 0);
    chk("R9", "word3 zero", rd(d + 12), 0);
    chk("R11", "buffer writes after descriptor", 32'(late_buf), 0);
    nx = model_next(d);
    chk("R10 R12", "pointer advance", hw_ptr, nx);
    b_hw = nx;
  endtask

  task automatic long_frame(int len);
    logic [31:0] ba, d, nx;
    d = b_hw;
    prep(ba, 0);
    send(len, 3, 0);
    chk("R8", "frame error pulses", 32'(n_err), 1);
    chk("R8", "good pulses", 32'(n_done + n_valid), 0);
    chk("R8", "too-long status", rd(d + 8), 32'h0010_0000);
    chk("R8", "buffer untouched", rd(ba), 32'hA5A5_A5A5);
    chk("R8", "only descriptor writes", 32'(wr_cnt), 4);
    chk("R9", "word1 zero", rd(d + 4), 0);
    chk("R9", "word3 zero", rd(d + 12), 0);
    nx = model_next(d);
    chk("R10", "pointer advance", hw_ptr, nx);
    b_hw = nx;
  endtask

  task automatic refused_frame(string tag);
    logic [31:0] d;
    d = b_hw;
    clr_counts();
    send(6, 9, 0);
    chk("R1", {tag, " writes"}, 32'(wr_cnt), 0);
    chk("R1", {tag, " reads"}, 32'(rd_cnt), 0);
    chk("R1", {tag, " pulses"}, 32'(n_done + n_valid + n_err + n_empty), 0);
    chk("R1", {tag, " pointer"}, hw_ptr, d);
  endtask

  initial begin
    b_base = 0; b_size = 16; b_hw = 0;
    repeat (3) @(negedge clk);
    chk("R3", "reset can_accept", {31'h0, can_accept}, 0);
    chk("R10", "reset pointer", hw_ptr, 0);
    chk("R4", "reset write strobe", {31'h0, mem_we}, 0);
    rst_n = 1;
    @(negedge clk);
    cfg(2'd0, 32'h2000);
    chk("R10", "base loads pointer", hw_ptr, 32'h2000);
    cfg(2'd0, RING);
    cfg(2'd1, 32'h35);
    cfg(2'd3, RING + 32'h40);
    chk("R3", "can_accept with room", {31'h0, can_accept}, 1);
    // directed lengths cover every end-byte value and the upper limit
    good_frame(0, 1, 0);
    good_frame(1, 2, 0);
    good_frame(2, 3, 0);
    good_frame(3, 4, 1);
    good_frame(1518, 5, 0);
    long_frame(1519);
    long_frame(2000);
    // empty ring
    cfg(2'd3, b_hw);
    chk("R3", "can_accept when equal", {31'h0, can_accept}, 0);
    clr_counts();
    send(10, 7, 0);
    chk("R2", "empty pulses", 32'(n_empty), 1);
    chk("R2", "writes while empty", 32'(wr_cnt), 0);
    chk("R2", "pointer held", hw_ptr, b_hw);
    cfg(2'd3, RING + 32'h40);
    chk("R3", "can_accept restored", {31'h0, can_accept}, 1);
    // refusal causes
    link_up = 0;   refused_frame("link down");  link_up = 1;
    rx_en = 0;     refused_frame("rx off");     rx_en = 1;
    rx_dma_en = 0; refused_frame("dma off");    rx_dma_en = 1;
    soft_rst = 1;  refused_frame("in reset");   soft_rst = 0;
    // random stream walking the ring
    void'($urandom(32'h5EED));
    for (int n = 0; n < 24; n++) good_frame(int'($urandom % 121), n + 20, 1);
    // size register select 1 with a different ring length (3 entries)
    cfg(2'd0, RING);
    cfg(2'd1, 32'h2F);
    for (int n = 0; n < 4; n++) good_frame(8 + n, 60 + n, 0);
    chk("R12", "pointer after 3-entry wrap", hw_ptr, RING + 32'h10);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule